// File: doc/BRIEF.md
# Converter Mode Register Controller

This block holds the operating-mode configuration of a four-channel converter and turns register accesses into control strobes and formatted read bursts. A byte write to any of four adjacent addresses updates one shared 8-bit mode register, and the two low address bits latch the channel that the requested mode acts on. Every such write aborts whatever the conversion engine is doing, clears the result status, releases the active-low result-pending output, and restarts the engine in the new mode one cycle later.

A simple parallel access port stands in for the serial front end. A read request is answered by a burst of bytes, one per cycle, starting the cycle after the request and marked on its final byte. Status and result data can be fetched separately. When chaining is enabled by the dump bit, or forced by the continuous-read bit, a read of either register returns the status byte followed by the data bytes. The result word is 24 bits, or its upper 16 bits in narrow mode. Results outside the nominal range can be saturated. A stub engine interface supplies results with over-range and under-range flags.

Top module: `cvt_mode_ctl`

## Requirements
- R1: After reset the mode register reads 00h, `res_pend_n` is 1, `eng_abort` and `eng_start` are 0 and no read burst is active.
- R2: A write to any address 38h to 3Bh loads the mode register and sets `eng_chan` to the address bits [1:0]. A write to any other address changes neither and raises no strobe.
- R3: A read at 38h returns the mode register as a single byte. A read at 39h, 3Ah, 3Bh or an unmapped address returns a single 00h byte.
- R4: Mode register fields are: [7:5] mode code, [4] clock-output disable, [3] dump, [2] continuous read, [1] width (1 = 24-bit), [0] clamp. `eng_mode` carries the mode code, except that the reserved code 101 is presented as 000 (idle).
- R5: In the cycle after a mode write, `eng_abort` is 1, `res_pend_n` is 1, the status byte is 00h and any read burst is cut off. In the cycle after that, `eng_start` is 1.
- R6: With dump and continuous read both 0, a read at 08h returns only the status byte, and a read at 10h returns only the data bytes. The status byte is {new result, over-range, under-range, 000, channel[1:0]}.
- R7: With dump 1, a read at 08h or 10h returns the status byte followed at once by the data bytes, and `rd_last` marks only the final byte.
- R8: With continuous read 1, reads at 08h and 10h are chained as in R7 whatever the dump bit holds.
- R9: With the width bit 1, the data bytes are result[23:16], [15:8], [7:0]. With it 0, they are result[23:16], [15:8].
- R10: With clamp 1 when the result is captured, an over-range result reads as all ones and an under-range result reads as all zeros. With clamp 0, the raw result is kept.
- R11: `clkout_oe` is the inverse of the clock-disable bit. `conv_halt` is 1 exactly when clock-disable is 1 and `xtal_sel` is 1.
- R12: `eng_done` drives `res_pend_n` low and sets the status new-result bit. An accepted read that includes the data bytes drives `res_pend_n` high again and clears that bit.
- R13: A read request that arrives while a burst is in progress is ignored: the burst continues unchanged and no extra burst follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Access request, one cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 8 | Register address |
| acc_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | Read burst byte valid |
| rd_byte | output | 8 | Read burst byte |
| rd_last | output | 1 | Final byte of the burst |
| xtal_sel | input | 1 | 1 = crystal clock source selected |
| clkout_oe | output | 1 | Clock output enable (0 = tristated) |
| conv_halt | output | 1 | Conversions halted by clock disable |
| eng_done | input | 1 | Engine result ready, one cycle |
| eng_result | input | 24 | Engine result word |
| eng_over | input | 1 | Result above nominal range |
| eng_under | input | 1 | Result below nominal range |
| eng_abort | output | 1 | Abort strobe to the engine |
| eng_start | output | 1 | Start strobe to the engine |
| eng_mode | output | 3 | Effective mode code |
| eng_chan | output | 2 | Latched channel |
| res_pend_n | output | 1 | Low while an unread result waits |

## Verification
The assertions assume that `eng_over` and `eng_under` are never both high, that `eng_done` never coincides with a mode write or with a read that takes the data, and that `rst` is held from time zero until after the first clock edge. The stimulus keeps to these conditions. Random range flags are drawn as one of none, over or under. Engine results, mode writes and reads are issued in separate cycles. The only access issued during a burst is the deliberate read that tests R13.

// File: rtl/cvt_pkg.sv
`timescale 1ns/1ps
package cvt_pkg;

    localparam int RES_W  = 24;
    localparam int BYTE_W = 8;
    localparam int BUF_W  = 4 * BYTE_W;

    typedef enum logic [2:0] {
        MD_IDLE    = 3'd0,
        MD_CONT    = 3'd1,
        MD_SINGLE  = 3'd2,
        MD_STBY    = 3'd3,
        MD_ZS_SELF = 3'd4,
        MD_RSVD    = 3'd5,
        MD_ZS_SYS  = 3'd6,
        MD_FS_SYS  = 3'd7
    } mode_e;

    typedef struct packed {
        mode_e mode;
        logic  clk_off;
        logic  chain;
        logic  cont_rd;
        logic  wide;
        logic  sat;
    } mode_reg_t;

    function automatic mode_e eff_mode(input mode_e m);
        return (m == MD_RSVD) ? MD_IDLE : m;
    endfunction

    function automatic logic [RES_W-1:0] saturate(input logic [RES_W-1:0] raw,
                                                  input logic over, input logic under,
                                                  input logic en);
        if (en && over)  return '1;
        if (en && under) return '0;
        return raw;
    endfunction

endpackage

// File: rtl/cvt_mode_reg.sv
`timescale 1ns/1ps
module cvt_mode_reg
    import cvt_pkg::*;
#(
    parameter int CH_W = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [CH_W-1:0] wr_ch,
    input  logic [7:0]      wr_data,
    output mode_reg_t       cfg,
    output logic [CH_W-1:0] chan,
    output logic            abort,
    output logic            start
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg   <= '0;
            chan  <= '0;
            abort <= 1'b0;
            start <= 1'b0;
        end else begin
            abort <= wr_en;
            start <= abort;
            if (wr_en) begin
                cfg  <= mode_reg_t'(wr_data);
                chan <= wr_ch;
            end
        end
    end

    // R5: restart follows the abort strobe by one cycle
    p_abort_start_r5: assert property (@(posedge clk) disable iff (rst)
        abort |=> start);

    // R2: configuration moves only on a decoded write
    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(cfg) && $stable(chan));

endmodule

// File: rtl/cvt_result_hold.sv
`timescale 1ns/1ps
module cvt_result_hold
    import cvt_pkg::*;
#(
    parameter int CH_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             done,
    input  logic [RES_W-1:0] raw,
    input  logic             over,
    input  logic             under,
    input  logic             sat_en,
    input  logic [CH_W-1:0]  chan,
    input  logic             taken,
    output logic [7:0]       status,
    output logic [RES_W-1:0] data,
    output logic             pend_n
);

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            data   <= '0;
            pend_n <= 1'b1;
        end else if (clr) begin
            status <= '0;
            pend_n <= 1'b1;
        end else if (done) begin
            status <= {1'b1, over, under, 5'(chan)};
            data   <= saturate(raw, over, under, sat_en);
            pend_n <= 1'b0;
        end else if (taken) begin
            status[7] <= 1'b0;
            pend_n    <= 1'b1;
        end
    end

    // R12: a captured result holds the pending output low
    p_done_pend_r12: assert property (@(posedge clk) disable iff (rst)
        done && !clr |=> !pend_n && status[7]);

    // R5: a mode write releases pending and empties status
    p_clr_status_r5: assert property (@(posedge clk) disable iff (rst)
        clr |=> pend_n && (status == 8'h00));

    // R10: saturation never yields a value on the wrong side
    p_sat_over_r10: assert property (@(posedge clk) disable iff (rst)
        done && !clr && sat_en && over |=> &data);

endmodule

// File: rtl/cvt_read_seq.sv
`timescale 1ns/1ps
module cvt_read_seq
    import cvt_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] MODE_ADDR = 8'h38,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h08,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cancel,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  mode_reg_t         cfg,
    input  logic [7:0]        status,
    input  logic [RES_W-1:0]  data,
    output logic              taken,
    output logic              rd_valid,
    output logic [7:0]        rd_byte,
    output logic              rd_last
);

    localparam int CNT_W = $clog2(BUF_W / BYTE_W + 1);

    logic [BUF_W-1:0] shreg, ld_buf, dbytes;
    logic [CNT_W-1:0] cnt, ld_cnt, dcnt;
    logic             accept, chained, is_reg;

    assign accept  = req && (cnt == '0) && !cancel;
    assign chained = cfg.chain || cfg.cont_rd;
    assign is_reg  = (addr == STAT_ADDR) || (addr == DATA_ADDR);

    always_comb begin
        dbytes = cfg.wide ? {data, 8'h00} : {data[RES_W-1:RES_W-16], 16'h0000};
        dcnt   = cfg.wide ? CNT_W'(3) : CNT_W'(2);
        ld_buf = '0;
        ld_cnt = CNT_W'(1);
        taken  = 1'b0;
        if (addr == MODE_ADDR) begin
            ld_buf = {cfg, 24'h0};
        end else if (is_reg && chained) begin
            ld_buf = {status, dbytes[BUF_W-1:8]};
            ld_cnt = dcnt + CNT_W'(1);
            taken  = accept;
        end else if (addr == STAT_ADDR) begin
            ld_buf = {status, 24'h0};
        end else if (addr == DATA_ADDR) begin
            ld_buf = dbytes;
            ld_cnt = dcnt;
            taken  = accept;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || cancel) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (accept) begin
            shreg <= ld_buf;
            cnt   <= ld_cnt;
        end else if (cnt != '0) begin
            shreg <= {shreg[BUF_W-9:0], 8'h00};
            cnt   <= cnt - CNT_W'(1);
        end
    end

    assign rd_valid = (cnt != '0);
    assign rd_byte  = shreg[BUF_W-1 -: 8];
    assign rd_last  = (cnt == CNT_W'(1));

    // R5: a mode write ends any burst
    p_cancel_r5: assert property (@(posedge clk) disable iff (rst)
        cancel |=> !rd_valid);

    // R13: an unfinished burst keeps going whatever is requested
    p_burst_cont_r13: assert property (@(posedge clk) disable iff (rst)
        rd_valid && !rd_last && !cancel |=> rd_valid);

    // R7: a burst ends in one marked byte and then stops unless a new one starts
    p_last_end_r7: assert property (@(posedge clk) disable iff (rst)
        rd_last && !req |=> !rd_valid);

endmodule

// File: rtl/cvt_mode_ctl.sv
`timescale 1ns/1ps
module cvt_mode_ctl
    import cvt_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                CH_W      = 2,
    parameter logic [ADDR_W-1:0] MODE_BASE = 8'h38,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h08,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [7:0]        acc_wdata,
    output logic              rd_valid,
    output logic [7:0]        rd_byte,
    output logic              rd_last,
    input  logic              xtal_sel,
    output logic              clkout_oe,
    output logic              conv_halt,
    input  logic              eng_done,
    input  logic [23:0]       eng_result,
    input  logic              eng_over,
    input  logic              eng_under,
    output logic              eng_abort,
    output logic              eng_start,
    output logic [2:0]        eng_mode,
    output logic [CH_W-1:0]   eng_chan,
    output logic              res_pend_n
);

    mode_reg_t        cfg;
    logic             mode_wr, rd_req, taken;
    logic [7:0]       status;
    logic [RES_W-1:0] data;

    assign mode_wr = acc_en && acc_wr && (acc_addr[ADDR_W-1:CH_W] == MODE_BASE[ADDR_W-1:CH_W]);
    assign rd_req  = acc_en && !acc_wr;

    cvt_mode_reg #(.CH_W(CH_W)) u_mreg (
        .clk(clk), .rst(rst), .wr_en(mode_wr),
        .wr_ch(acc_addr[CH_W-1:0]), .wr_data(acc_wdata),
        .cfg(cfg), .chan(eng_chan), .abort(eng_abort), .start(eng_start)
    );

    cvt_result_hold #(.CH_W(CH_W)) u_hold (
        .clk(clk), .rst(rst), .clr(mode_wr), .done(eng_done),
        .raw(eng_result), .over(eng_over), .under(eng_under),
        .sat_en(cfg.sat), .chan(eng_chan), .taken(taken),
        .status(status), .data(data), .pend_n(res_pend_n)
    );

    cvt_read_seq #(
        .ADDR_W(ADDR_W), .MODE_ADDR(MODE_BASE),
        .STAT_ADDR(STAT_ADDR), .DATA_ADDR(DATA_ADDR)
    ) u_rseq (
        .clk(clk), .rst(rst), .cancel(mode_wr), .req(rd_req),
        .addr(acc_addr), .cfg(cfg), .status(status), .data(data),
        .taken(taken), .rd_valid(rd_valid), .rd_byte(rd_byte), .rd_last(rd_last)
    );

    assign eng_mode  = eff_mode(cfg.mode);
    assign clkout_oe = !cfg.clk_off;
    assign conv_halt = cfg.clk_off && xtal_sel;

    // R4: the reserved code never reaches the engine
    p_rsvd_idle_r4: assert property (@(posedge clk) disable iff (rst)
        eng_mode != 3'b101);

    // R11: a halted converter never drives the clock output
    p_halt_tristate_r11: assert property (@(posedge clk) disable iff (rst)
        conv_halt |-> !clkout_oe);

    // R5: every window write is followed by an abort strobe
    p_wr_abort_r5: assert property (@(posedge clk) disable iff (rst)
        mode_wr |=> eng_abort && res_pend_n);

endmodule

// File: tb/sim_cvt_mode_ctl.sv
`timescale 1ns/1ps
module sim_cvt_mode_ctl;

    localparam logic [7:0] A_MODE = 8'h38;
    localparam logic [7:0] A_STAT = 8'h08;
    localparam logic [7:0] A_DATA = 8'h10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_en = 1'b0, acc_wr = 1'b0;
    logic [7:0]  acc_addr = '0, acc_wdata = '0;
    logic        rd_valid, rd_last;
    logic [7:0]  rd_byte;
    logic        xtal_sel = 1'b0, clkout_oe, conv_halt;
    logic        eng_done = 1'b0, eng_over = 1'b0, eng_under = 1'b0;
    logic [23:0] eng_result = '0;
    logic        eng_abort, eng_start, res_pend_n;
    logic [2:0]  eng_mode;
    logic [1:0]  eng_chan;

    int checks = 0;
    int errors = 0;

    logic [7:0]  m_byte = 8'h00;
    logic [1:0]  m_chan = 2'd0;
    logic [7:0]  m_status = 8'h00;
    logic [23:0] m_data = '0;
    logic        m_pend = 1'b1;

    always #2 clk = ~clk;

    cvt_mode_ctl u0 (
        .clk(clk), .rst(rst), .acc_en(acc_en), .acc_wr(acc_wr),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .rd_valid(rd_valid), .rd_byte(rd_byte), .rd_last(rd_last),
        .xtal_sel(xtal_sel), .clkout_oe(clkout_oe), .conv_halt(conv_halt),
        .eng_done(eng_done), .eng_result(eng_result),
        .eng_over(eng_over), .eng_under(eng_under),
        .eng_abort(eng_abort), .eng_start(eng_start),
        .eng_mode(eng_mode), .eng_chan(eng_chan), .res_pend_n(res_pend_n)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_mode(input logic [7:0] b);
        return (b[7:5] == 3'b101) ? 3'b000 : b[7:5];
    endfunction

    function automatic logic [23:0] exp_sat(input logic [23:0] raw, input logic ov,
                                           input logic un, input logic en);
        if (en && ov) return 24'hFFFFFF;
        if (en && un) return 24'h000000;
        return raw;
    endfunction

    task automatic expect_read(input logic [7:0] a, output logic [31:0] b,
                               output int n, output bit takes);
        logic [31:0] db;
        int dn;
        bit ch;
        db = m_byte[1] ? {m_data, 8'h00} : {m_data[23:8], 16'h0000};
        dn = m_byte[1] ? 3 : 2;
        ch = m_byte[3] | m_byte[2];
        takes = 1'b0;
        b = '0;
        n = 1;
        if (a == A_MODE) begin
            b = {m_byte, 24'h0};
        end else if ((a == A_STAT || a == A_DATA) && ch) begin
            b = {m_status, db[31:8]};
            n = dn + 1;
            takes = 1'b1;
        end else if (a == A_STAT) begin
            b = {m_status, 24'h0};
        end else if (a == A_DATA) begin
            b = db;
            n = dn;
            takes = 1'b1;
        end
    endtask

    task automatic do_read(input logic [7:0] a, input string req);
        logic [31:0] b;
        int n;
        bit takes;
        expect_read(a, b, n, takes);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = 1'b0; acc_addr = a;
        @(negedge clk);
        acc_en = 1'b0;
        for (int i = 0; i < n; i++) begin
            check(rd_valid === 1'b1, req, {31'b0, rd_valid}, 32'd1);
            check(rd_byte === b[31-8*i -: 8], req, {24'b0, rd_byte}, {24'b0, b[31-8*i -: 8]});
            check(rd_last === (i == n - 1), req, {31'b0, rd_last}, {31'b0, (i == n - 1)});
            @(negedge clk);
        end
        check(rd_valid === 1'b0, req, {31'b0, rd_valid}, 32'd0);
        if (takes) begin
            m_pend = 1'b1;
            m_status[7] = 1'b0;
        end
        check(res_pend_n === m_pend, "R12", {31'b0, res_pend_n}, {31'b0, m_pend});
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        bit hit;
        hit = (a[7:2] == A_MODE[7:2]);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = 1'b1; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_en = 1'b0; acc_wr = 1'b0;
        if (hit) begin
            m_byte = d; m_chan = a[1:0]; m_status = 8'h00; m_pend = 1'b1;
            check(eng_abort === 1'b1, "R5", {31'b0, eng_abort}, 32'd1);
            check(res_pend_n === 1'b1, "R5", {31'b0, res_pend_n}, 32'd1);
            check(eng_chan === m_chan, "R2", {30'b0, eng_chan}, {30'b0, m_chan});
            check(eng_mode === exp_mode(m_byte), "R4", {29'b0, eng_mode}, {29'b0, exp_mode(m_byte)});
            @(negedge clk);
            check(eng_start === 1'b1, "R5", {31'b0, eng_start}, 32'd1);
        end else begin
            check(eng_abort === 1'b0, "R2", {31'b0, eng_abort}, 32'd0);
            @(negedge clk);
            check(eng_start === 1'b0, "R2", {31'b0, eng_start}, 32'd0);
        end
    endtask

    task automatic do_done(input logic [23:0] raw, input logic ov, input logic un);
        @(negedge clk);
        eng_done = 1'b1; eng_result = raw; eng_over = ov; eng_under = un;
        @(negedge clk);
        eng_done = 1'b0; eng_over = 1'b0; eng_under = 1'b0;
        m_status = {1'b1, ov, un, 3'b000, m_chan};
        m_data = exp_sat(raw, ov, un, m_byte[0]);
        m_pend = 1'b0;
        check(res_pend_n === 1'b0, "R12", {31'b0, res_pend_n}, 32'd0);
    endtask

    task automatic check_clk(input logic xs);
        @(negedge clk);
        xtal_sel = xs;
        #1;
        check(clkout_oe === ~m_byte[4], "R11", {31'b0, clkout_oe}, {31'b0, ~m_byte[4]});
        check(conv_halt === (m_byte[4] & xs), "R11", {31'b0, conv_halt}, {31'b0, m_byte[4] & xs});
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check(res_pend_n === 1'b1, "R1", {31'b0, res_pend_n}, 32'd1);
        check(rd_valid === 1'b0, "R1", {31'b0, rd_valid}, 32'd0);
        check(eng_abort === 1'b0 && eng_start === 1'b0, "R1", {30'b0, eng_abort, eng_start}, 32'd0);
        do_read(A_MODE, "R1");

        // R2: write outside the window is ignored
        do_write(8'h3C, 8'hFF);
        do_read(A_MODE, "R2");
        do_write(8'h37, 8'hAA);
        do_read(A_MODE, "R2");

        // R4: reserved code reads back but drives idle
        do_write(8'h3A, 8'hA0);
        do_read(A_MODE, "R4");
        // R3: alias addresses do not read the mode register
        do_read(8'h39, "R3");
        do_read(8'h3A, "R3");
        do_read(8'h3B, "R3");
        do_read(8'h55, "R3");

        // R6: separate reads, wide, no clamp
        do_write(8'h39, 8'h22);
        do_done(24'hABCDEF, 1'b0, 1'b0);
        do_read(A_STAT, "R6");
        do_read(A_DATA, "R9");
        do_read(A_STAT, "R12");

        // R10: clamp over-range in narrow mode
        do_write(8'h3B, 8'h41);
        do_done(24'h123456, 1'b1, 1'b0);
        do_read(A_DATA, "R10");
        // R10: clamp under-range, wide
        do_write(8'h38, 8'h43);
        do_done(24'h7F00AA, 1'b0, 1'b1);
        do_read(A_DATA, "R10");
        // R10: no clamp keeps raw
        do_write(8'h38, 8'h42);
        do_done(24'hFEDCBA, 1'b1, 1'b0);
        do_read(A_DATA, "R10");

        // R5: mode write clears captured status
        do_done(24'h111111, 1'b0, 1'b1);
        do_write(8'h39, 8'h40);
        do_read(A_STAT, "R5");

        // R7: dump chains from the status address
        do_write(8'h3A, 8'h2A);
        do_done(24'h0055AA, 1'b0, 1'b0);
        do_read(A_STAT, "R7");
        // R8: continuous read chains without dump
        do_write(8'h3B, 8'h24);
        do_done(24'hC0FFEE, 1'b0, 1'b0);
        do_read(A_DATA, "R8");

        // R13: request during a burst is ignored
        do_write(8'h38, 8'h22);
        do_done(24'h9A8B7C, 1'b0, 1'b0);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = 1'b0; acc_addr = A_DATA;
        @(negedge clk);
        check(rd_byte === 8'h9A, "R13", {24'b0, rd_byte}, 32'h9A);
        acc_addr = A_STAT;
        @(negedge clk);
        acc_en = 1'b0;
        check(rd_byte === 8'h8B, "R13", {24'b0, rd_byte}, 32'h8B);
        @(negedge clk);
        check(rd_byte === 8'h7C && rd_last === 1'b1, "R13", {23'b0, rd_last, rd_byte}, 32'h17C);
        @(negedge clk);
        check(rd_valid === 1'b0, "R13", {31'b0, rd_valid}, 32'd0);
        m_pend = 1'b1; m_status[7] = 1'b0;

        // R5: a mode write cuts off a burst
        do_done(24'h445566, 1'b0, 1'b0);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = 1'b0; acc_addr = A_DATA;
        @(negedge clk);
        acc_wr = 1'b1; acc_addr = 8'h38; acc_wdata = 8'h00;
        @(negedge clk);
        acc_en = 1'b0; acc_wr = 1'b0;
        check(rd_valid === 1'b0, "R5", {31'b0, rd_valid}, 32'd0);
        m_byte = 8'h00; m_chan = 2'd0; m_status = 8'h00; m_pend = 1'b1;

        // R11: clock output controls
        do_write(8'h38, 8'h10);
        check_clk(1'b1);
        check_clk(1'b0);

        // random mix
        for (int k = 0; k < 300; k++) begin
            logic [7:0]  d;
            logic [7:0]  a;
            logic [23:0] r;
            int          f;
            d = 8'($urandom);
            a = 8'h38 + 8'($urandom % 4);
            r = 24'($urandom);
            f = $urandom % 4;
            do_write(a, d);
            do_read(A_MODE, "R2");
            check_clk(1'($urandom));
            do_done(r, f == 1, f == 2);
            case ($urandom % 4)
                0: begin do_read(A_STAT, "R6"); do_read(A_DATA, "R9"); end
                1: do_read(A_DATA, "R9");
                2: do_read(A_STAT, "R7");
                default: do_read(8'h39 + 8'($urandom % 3), "R3");
            endcase
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule